// File: doc/BRIEF.md
# Banked Index/Data Access Port for a Real-Time Clock

This block gives a host processor byte-wide access to a real-time clock's control registers and to a 256-byte battery-backed storage array. The host sees four port offsets. Offset 0 holds an index. Offset 1 reads or writes the byte that index selects among locations 0 to 127. Offsets 2 and 3 form a second index/data pair, and that pair reaches locations 128 to 255: a stored index `i` there selects location `128 + i`.

In the lower bank, indices 10 to 13 are not storage. They reach four control registers:

- A rate register that also reports an update-busy status bit.
- An enable register.
- A read-to-clear event-flag register.
- A fixed validity register.

Every other location, including the time locations, lives in the storage array.

Three single-cycle event inputs from the timekeeping logic (periodic, alarm, update-ended) set sticky flags. The enable register gates these flags into a summary bit. That summary bit drives the interrupt request output.

Top module: `rtc_index_port`

## Requirements
- R1: A write at offset 0 stores bits 6:0 of the data as the low-bank index. A read or write at offset 1 accesses location `{0, index}`. Read data appears on `host_rdata` one clock after the read strobe is sampled and holds until the next read.
- R2: Offset 2 stores the high-bank index. Offset 3 accesses location `128 + index`. The two banks and their indices are independent of each other.
- R3: Control registers exist only at low-bank indices 10 (rate), 11 (enable), 12 (flags) and 13 (validity). High-bank indices 10 to 13 are ordinary storage.
- R4: In the rate register, bits 6:0 are read/write. Bit 7 reads the `update_busy` input, and host writes to bit 7 are ignored.
- R5: The enable register is fully read/write and resets to 0x00. Its bit 6 enables periodic, bit 5 enables alarm and bit 4 enables update-ended.
- R6: In the flag register, an event pulse sets its flag whatever the enable is: bit 6 is periodic, bit 5 is alarm and bit 4 is update-ended. Bits 3:0 read 0. Bit 7 reads 1 when any flag is set together with its enable bit.
- R7: A read of the flag register returns its current value and clears all of its flags on the same clock edge.
- R8: An event that arrives in the same cycle as a clearing read leaves its flag set after that read.
- R9: Host writes to the flag register have no effect.
- R10: The validity register always reads 0x80, and host writes to it are ignored.
- R11: `irq` is high exactly while flag-register bit 7 is set.
- R12: Bit 7 of a written index is ignored. A read at offset 0 or 2 returns that bank's index with bit 7 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_ofs | input | 2 | Port offset: 0/2 index, 1/3 data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| update_busy | input | 1 | Update-in-progress status from the timekeeper |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted index or bank select shows up on the first data read after it: that read returns a byte written elsewhere, or returns a control value instead of a storage value. A lost or stale flag becomes visible on the next flag-register read, and also on `irq` one clock after the event or enable change. The bench therefore reads the flag register again right after each clearing read. It also reads the flag register right after an event that collides with a clearing read, so that a missed clear or a dropped event is seen within two accesses.

// File: rtl/rtc_index_port.sv
module rtc_index_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [1:0] host_ofs,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       update_busy,
  input  logic       ev_periodic,
  input  logic       ev_alarm,
  input  logic       ev_update,
  output logic       irq
);
  localparam int          DEPTH = 256;
  localparam int          IW    = $clog2(DEPTH) - 1;
  localparam logic [IW-1:0] IX_RATE = 10;
  localparam logic [IW-1:0] IX_EN   = 11;
  localparam logic [IW-1:0] IX_FLG  = 12;
  localparam logic [IW-1:0] IX_VAL  = 13;

  logic [IW-1:0] idx_lo, idx_hi;
  logic [6:0]    rate;
  logic [7:0]    en;
  logic          pf, af, uf;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    rmux;

  wire          data_lo = host_ofs == 2'd1;
  wire          data_hi = host_ofs == 2'd3;
  wire [IW:0]   addr    = data_hi ? {1'b1, idx_hi} : {1'b0, idx_lo};
  wire          is_ctl  = data_lo && idx_lo >= IX_RATE && idx_lo <= IX_VAL;
  wire          summ    = (pf & en[6]) | (af & en[5]) | (uf & en[4]);
  wire [7:0]    flg     = {summ, pf, af, uf, 4'b0000};
  wire          rd_flg  = host_rd && data_lo && idx_lo == IX_FLG;
  wire          ctl_wr  = host_wr && data_lo;

  assign irq = summ;

  always_comb begin
    case (host_ofs)
      2'd0: rmux = {1'b0, idx_lo};
      2'd2: rmux = {1'b0, idx_hi};
      default: begin
        if (is_ctl) begin
          case (idx_lo)
            IX_RATE: rmux = {update_busy, rate};
            IX_EN:   rmux = en;
            IX_FLG:  rmux = flg;
            default: rmux = 8'h80;
          endcase
        end else begin
          rmux = mem[addr];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_lo     <= '0;
      idx_hi     <= '0;
      rate       <= '0;
      en         <= '0;
      pf         <= 1'b0;
      af         <= 1'b0;
      uf         <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_wr && host_ofs == 2'd0) idx_lo <= host_wdata[IW-1:0];
      if (host_wr && host_ofs == 2'd2) idx_hi <= host_wdata[IW-1:0];
      if (ctl_wr && idx_lo == IX_RATE) rate <= host_wdata[6:0];
      if (ctl_wr && idx_lo == IX_EN)   en   <= host_wdata;
      pf <= (pf & ~rd_flg) | ev_periodic;
      af <= (af & ~rd_flg) | ev_alarm;
      uf <= (uf & ~rd_flg) | ev_update;
      if (host_rd) host_rdata <= rmux;
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr && (data_lo || data_hi) && !is_ctl) mem[addr] <= host_wdata;
  end

  a_r12_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_ofs == 2'd0 |=> idx_lo == $past(host_wdata[IW-1:0]));

  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flg && !ev_periodic && !ev_alarm && !ev_update |=> flg == 8'h00);

  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flg && ev_alarm |=> af);

  a_r10_valid_const: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && data_lo && idx_lo == IX_VAL |=> host_rdata == 8'h80);

  a_r4_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && data_lo && idx_lo == IX_RATE |=> host_rdata[7] == $past(update_busy));

  a_r11_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ev_update && en[4] && !(ctl_wr && idx_lo == IX_EN) |=> irq);
endmodule

// File: tb/tb_rtc_index_port.sv
module tb_rtc_index_port;
  logic       clk = 0, rst_n = 0;
  logic       host_wr = 0, host_rd = 0;
  logic [1:0] host_ofs = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       update_busy = 0, ev_periodic = 0, ev_alarm = 0, ev_update = 0;
  logic       irq;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  rtc_index_port dut (.*);

  always #2 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (host_rd && rst_n) begin
      #1;
      if (exp_q.size() == 0) begin
        check(0, "monitor: unexpected read", host_rdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_ofs = o; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] o, input logic [7:0] e, input string t);
    @(negedge clk);
    host_rd = 1; host_ofs = o;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ev_periodic = 1;
    if (which == 1) ev_alarm = 1;
    if (which == 2) ev_update = 1;
    @(negedge clk);
    ev_periodic = 0; ev_alarm = 0; ev_update = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(0, 8'h00, "R12 reset index");
    check(irq === 1'b0, "R11 reset irq", irq, 0);
    wr(0, 13); rd(1, 8'h80, "R10 reset validity");
    wr(0, 12); rd(1, 8'h00, "R6 reset flags");
    wr(0, 11); rd(1, 8'h00, "R5 reset enables");
    // low bank storage
    wr(0, 8'h20); wr(1, 8'h5A);
    rd(1, 8'h5A, "R1 low bank data");
    rd(0, 8'h20, "R1 index readback");
    wr(0, 8'hA0);
    rd(0, 8'h20, "R12 index bit7 ignored");
    rd(1, 8'h5A, "R12 same location");
    // high bank
    wr(2, 8'h20); wr(3, 8'hC3);
    rd(3, 8'hC3, "R2 high bank data");
    rd(1, 8'h5A, "R2 low bank untouched");
    wr(2, 10); wr(3, 8'h77);
    rd(3, 8'h77, "R3 high index 10 is storage");
    // rate register
    wr(0, 10); wr(1, 8'hFF);
    rd(1, 8'h7F, "R4 busy bit write ignored");
    update_busy = 1;
    rd(1, 8'hFF, "R4 busy bit reflects input");
    update_busy = 0;
    // flags and irq
    wr(0, 11); wr(1, 8'h00);
    pulse(0);
    check(irq === 1'b0, "R11 disabled event no irq", irq, 0);
    wr(0, 12);
    rd(1, 8'h40, "R6 periodic flag");
    rd(1, 8'h00, "R7 cleared after read");
    pulse(1);
    wr(0, 11); wr(1, 8'h20);
    check(irq === 1'b1, "R11 enabled alarm irq", irq, 1);
    wr(0, 12);
    rd(1, 8'hA0, "R6 summary with alarm");
    check(irq === 1'b0, "R11 irq drops after clear", irq, 0);
    pulse(2);
    wr(1, 8'h00);
    rd(1, 8'h10, "R9 write to flags ignored");
    rd(1, 8'h00, "R7 cleared again");
    // collision
    @(negedge clk);
    host_rd = 1; host_ofs = 1; ev_alarm = 1;
    exp_q.push_back(8'h00); tag_q.push_back("R8 collision read value");
    @(negedge clk);
    host_rd = 0; ev_alarm = 0;
    check(irq === 1'b1, "R8 irq after collision", irq, 1);
    rd(1, 8'hA0, "R8 alarm flag kept");
    // validity write
    wr(0, 13); wr(1, 8'h00);
    rd(1, 8'h80, "R10 validity write ignored");
    wr(0, 11); wr(1, 8'h5B);
    rd(1, 8'h5B, "R5 enable readback");
    wr(0, 8'h20);
    rd(1, 8'h5A, "R3 storage outside control range");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "monitor queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule